// File: doc/BRIEF.md
# DMA Channel Command Register

A single 32-bit command word controls up to three descriptor-driven DMA channels. Software reaches it through a plain register port with select, enable and write strobes. One write carries three things: a descriptor address aligned to 64 bytes, a channel number, and one command. The command can launch a channel from that descriptor, take a snapshot of the channel's live descriptor state into memory at that address, or halt the channel. Launch and snapshot commands stay visible in the word until the action is complete. Software polls the word to learn when the action has finished.

The unit does not move data itself. It raises a held launch request toward the chosen channel's descriptor engine, and that request drops once the engine acknowledges. A halt becomes a one-cycle pulse. A snapshot becomes a seven-word burst on a valid/ready memory write port. The unit steps the snapshot index, and the selected engine presents the matching word of its state.

Back-pressure rules for the write port:
- Once `wb_valid` rises, it stays high until the word is taken (`wb_valid && wb_ready` at a clock edge).
- While a word waits, `wb_addr` and `wb_data` stay stable.
- The engines must keep the word at `snap_idx` stable while it is presented.

Top module: `dma_cmd_unit`

## Requirements
- R1: After reset the word reads 0, no launch request or halt pulse is active, and `wb_valid` is low.
- R2: An accepted write stores bits [31:6] as the descriptor address and bits [1:0] as the channel. A read returns those fields, with the launch flag in bit 3 and the snapshot flag in bit 2. Bits 5 and 4 read as 0.
- R3: A write whose channel field is 3 (not below the channel count), or that has bit 5 set, is ignored and leaves the word unchanged.
- R4: Bit 3 (launch) sets the launch flag. The chosen channel's `ch_start_req` line is then high from the next cycle, with `ch_start_addr` equal to the address field followed by six zero bits. The flag and the request clear on the cycle after that channel's `ch_start_ack` is sampled high.
- R5: Bit 2 (snapshot) sets the snapshot flag and emits seven words. Word k goes to base+4k, and its data is the chosen channel's snapshot word presented while `snap_idx` = k.
- R6: While `wb_ready` is low, `wb_valid`, `wb_addr` and `wb_data` hold.
- R7: The snapshot flag clears on the cycle after the seventh word is accepted. A write sampled in that same cycle is still ignored.
- R8: Bit 4 (halt) gives a one-cycle pulse on the chosen channel's `ch_stop` line, in the cycle after the write. The address and channel are stored, and the halt bit reads back as 0.
- R9: While a launch or snapshot flag is set, every write is ignored.
- R10: If one write sets several command bits, halt wins over snapshot, and snapshot wins over launch. Only the winner takes effect.
- R11: An acknowledge on a channel other than the one with a pending launch has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register select |
| bus_enable | input | 1 | Access phase |
| bus_write | input | 1 | 1 = write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Command word readback |
| ch_start_req | output | NCH | Held launch request per channel |
| ch_start_addr | output | 32 | Descriptor address for launch |
| ch_start_ack | input | NCH | Engine accepted the launch |
| ch_stop | output | NCH | One-cycle halt pulse per channel |
| snap_idx | output | 3 | Snapshot word index presented to engines |
| snap_data | input | NCH*32 | Snapshot word of each engine at `snap_idx` |
| wb_valid | output | 1 | Write-back word valid |
| wb_ready | input | 1 | Memory accepts the word |
| wb_addr | output | 32 | Write-back byte address |
| wb_data | output | 32 | Write-back data |

## Verification
Two functions can land on one clock edge: a new register write, and the completion of a pending action. The completion is either the last snapshot word being accepted or the launch acknowledge. The bench provokes this by timing a write to be sampled on exactly the edge where the seventh word is taken. It also drives acknowledges of foreign channels while a launch is pending. A behavioural model in the bench predicts every output on every cycle. The coincident write is judged ignored, because the flag was still set when the write was sampled, so the word must show the old channel and address with both flags clear.

// File: rtl/dmacmd_pkg.sv
package dmacmd_pkg;
  localparam int BIT_ASK   = 2;
  localparam int BIT_START = 3;
  localparam int BIT_STOP  = 4;
  localparam int BIT_RSVD  = 5;
  localparam int ALIGN_LSB = 6;
  localparam int CHAN_W    = 2;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_STOP,
    CMD_ASK,
    CMD_START
  } cmd_e;
endpackage

// File: rtl/dmacmd_decode.sv
module dmacmd_decode
  import dmacmd_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 32
) (
  input  logic              wr_fire,
  input  logic              busy,
  input  logic [DW-1:0]     wdata,
  output logic              accept,
  output cmd_e              cmd,
  output logic [CHAN_W-1:0] chan,
  output logic [DW-ALIGN_LSB-1:0] addr
);
  assign chan   = wdata[CHAN_W-1:0];
  assign addr   = wdata[DW-1:ALIGN_LSB];
  assign accept = wr_fire && !busy && !wdata[BIT_RSVD] && (32'(chan) < NCH);

  // halt outranks snapshot, snapshot outranks launch
  always_comb begin
    if (wdata[BIT_STOP])       cmd = CMD_STOP;
    else if (wdata[BIT_ASK])   cmd = CMD_ASK;
    else if (wdata[BIT_START]) cmd = CMD_START;
    else                       cmd = CMD_NONE;
  end
endmodule

// File: rtl/dmacmd_chan_if.sv
module dmacmd_chan_if
  import dmacmd_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pend,
  input  logic [CHAN_W-1:0] start_chan,
  input  logic              stop_fire,
  input  logic [CHAN_W-1:0] stop_chan,
  input  logic [NCH-1:0]    start_ack,
  output logic [NCH-1:0]    start_req,
  output logic [NCH-1:0]    stop,
  output logic              ack_hit
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign start_req[c] = start_pend && (start_chan == CHAN_W'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stop[c] <= 1'b0;
      else        stop[c] <= stop_fire && (stop_chan == CHAN_W'(c));
    end
  end
  assign ack_hit = |(start_ack & start_req);
endmodule

// File: rtl/dmacmd_dumper.sv
module dmacmd_dumper
  import dmacmd_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int DW    = 32,
  parameter int WORDS = 7,
  parameter int IDXW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [CHAN_W-1:0] chan,
  input  logic [DW-1:0]     base,
  input  logic [NCH*DW-1:0] snap_data,
  input  logic              wb_ready,
  output logic              active,
  output logic [IDXW-1:0]   idx,
  output logic              wb_valid,
  output logic [DW-1:0]     wb_addr,
  output logic [DW-1:0]     wb_data
);
  localparam logic [IDXW-1:0] LAST = IDXW'(WORDS - 1);

  logic [DW-1:0] words [NCH];
  for (genvar c = 0; c < NCH; c++) begin : g_w
    assign words[c] = snap_data[c*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (launch) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active && wb_ready) begin
      if (idx == LAST) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    wb_data = '0;
    for (int c = 0; c < NCH; c++)
      if (chan == CHAN_W'(c)) wb_data = words[c];
  end

  assign wb_valid = active;
  assign wb_addr  = base + {{(DW-IDXW-2){1'b0}}, idx, 2'b00};
endmodule

// File: rtl/dma_cmd_unit.sv
module dma_cmd_unit
  import dmacmd_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int DW    = 32,
  parameter int WORDS = 7,
  parameter int IDXW  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_enable,
  input  logic              bus_write,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NCH-1:0]    ch_start_req,
  output logic [DW-1:0]     ch_start_addr,
  input  logic [NCH-1:0]    ch_start_ack,
  output logic [NCH-1:0]    ch_stop,
  output logic [IDXW-1:0]   snap_idx,
  input  logic [NCH*DW-1:0] snap_data,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [DW-1:0]     wb_addr,
  output logic [DW-1:0]     wb_data
);
  localparam int ABITS = DW - ALIGN_LSB;

  logic [ABITS-1:0]  addr_q;
  logic [CHAN_W-1:0] chan_q;
  logic              start_q;
  logic              ask_q;
  logic              busy, wr_fire, accept, ack_hit;
  cmd_e              cmd;
  logic [CHAN_W-1:0] wchan;
  logic [ABITS-1:0]  waddr;
  logic [DW-1:0]     base;

  assign wr_fire = bus_sel && bus_enable && bus_write;
  assign busy    = start_q || ask_q;
  assign base    = {addr_q, {ALIGN_LSB{1'b0}}};

  dmacmd_decode #(.NCH(NCH), .DW(DW)) u_dec (
    .wr_fire(wr_fire), .busy(busy), .wdata(bus_wdata),
    .accept(accept), .cmd(cmd), .chan(wchan), .addr(waddr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      chan_q  <= '0;
      start_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= waddr;
      chan_q  <= wchan;
      start_q <= (cmd == CMD_START);
    end else if (start_q && ack_hit) begin
      start_q <= 1'b0;
    end
  end

  dmacmd_chan_if #(.NCH(NCH)) u_ch (
    .clk(clk), .rst_n(rst_n),
    .start_pend(start_q), .start_chan(chan_q),
    .stop_fire(accept && (cmd == CMD_STOP)), .stop_chan(wchan),
    .start_ack(ch_start_ack), .start_req(ch_start_req),
    .stop(ch_stop), .ack_hit(ack_hit)
  );

  dmacmd_dumper #(.NCH(NCH), .DW(DW), .WORDS(WORDS), .IDXW(IDXW)) u_dump (
    .clk(clk), .rst_n(rst_n),
    .launch(accept && (cmd == CMD_ASK)), .chan(chan_q), .base(base),
    .snap_data(snap_data), .wb_ready(wb_ready),
    .active(ask_q), .idx(snap_idx),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  always_comb begin
    bus_rdata                   = '0;
    bus_rdata[DW-1:ALIGN_LSB]   = addr_q;
    bus_rdata[BIT_START]        = start_q;
    bus_rdata[BIT_ASK]          = ask_q;
    bus_rdata[CHAN_W-1:0]       = chan_q;
  end

  assign ch_start_addr = base;
endmodule

// File: rtl/dmacmd_checker.sv
module dmacmd_checker
  import dmacmd_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int DW    = 32,
  parameter int WORDS = 7,
  parameter int IDXW  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_enable,
  input logic              bus_write,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [NCH-1:0]    ch_start_req,
  input logic [NCH-1:0]    ch_start_ack,
  input logic [NCH-1:0]    ch_stop,
  input logic [IDXW-1:0]   snap_idx,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [DW-1:0]     wb_addr,
  input logic [DW-1:0]     wb_data
);
  localparam logic [IDXW-1:0] LAST = IDXW'(WORDS - 1);
  logic wr, pend;
  assign wr   = bus_sel && bus_enable && bus_write;
  assign pend = wb_valid || (|ch_start_req);

  AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ch_start_req & ~ch_start_ack)) |=> (ch_start_req == $past(ch_start_req))); // R4
  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_start_req)); // R4
  AST_STOP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_stop)); // R8
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data))); // R6
  AST_ASK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready && snap_idx == LAST) |=> !wb_valid); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && pend) |=> (bus_rdata[DW-1:ALIGN_LSB] == $past(bus_rdata[DW-1:ALIGN_LSB])
                      && bus_rdata[CHAN_W-1:0] == $past(bus_rdata[CHAN_W-1:0]))); // R9
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && (|ch_start_req))); // R9
  AST_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !pend && (bus_wdata[BIT_RSVD] || 32'(bus_wdata[CHAN_W-1:0]) >= NCH))
      |=> (bus_rdata == $past(bus_rdata))); // R3
endmodule

bind dma_cmd_unit dmacmd_checker #(.NCH(NCH), .DW(DW), .WORDS(WORDS), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_enable(bus_enable),
  .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ch_start_req(ch_start_req), .ch_start_ack(ch_start_ack), .ch_stop(ch_stop),
  .snap_idx(snap_idx), .wb_valid(wb_valid), .wb_ready(wb_ready),
  .wb_addr(wb_addr), .wb_data(wb_data)
);

// File: tb/sim_dma_cmd_unit.sv
module sim_dma_cmd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_enable = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  ch_start_req, ch_stop;
  logic [2:0]  ch_start_ack = '0;
  logic [31:0] ch_start_addr;
  logic [2:0]  snap_idx;
  logic [95:0] snap_data;
  logic        wb_valid;
  logic        wb_ready = 1'b0;
  logic [31:0] wb_addr, wb_data;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  dma_cmd_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_enable(bus_enable),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_start_req(ch_start_req), .ch_start_addr(ch_start_addr),
    .ch_start_ack(ch_start_ack), .ch_stop(ch_stop), .snap_idx(snap_idx),
    .snap_data(snap_data), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_addr(wb_addr), .wb_data(wb_data)
  );

  function automatic logic [31:0] snapw(int c, int k);
    return 32'hA500_0000 | 32'(c << 12) | 32'(k << 4) | 32'(c + k);
  endfunction

  always_comb begin
    for (int c = 0; c < 3; c++) snap_data[c*32 +: 32] = snapw(c, int'(snap_idx));
  end

  // behavioural reference model
  logic [25:0] m_addr = '0;
  int          m_chan = 0, m_idx = 0;
  bit          m_start = 0, m_ask = 0;
  logic [2:0]  m_stop = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = '0; m_chan = 0; m_idx = 0; m_start = 0; m_ask = 0; m_stop = '0;
    end else begin
      bit busy;
      logic [2:0] nstop;
      busy  = m_start || m_ask;
      nstop = '0;
      if (m_start && ch_start_ack[m_chan]) m_start = 0;
      if (m_ask && wb_ready) begin
        if (m_idx == 6) begin m_ask = 0; m_idx = 0; end
        else m_idx++;
      end
      if (bus_sel && bus_enable && bus_write && !busy &&
          bus_wdata[1:0] < 2'd3 && !bus_wdata[5]) begin
        m_addr = bus_wdata[31:6];
        m_chan = int'(bus_wdata[1:0]);
        if (bus_wdata[4]) nstop[m_chan] = 1'b1;
        else if (bus_wdata[2]) begin m_ask = 1; m_idx = 0; end
        else if (bus_wdata[3]) m_start = 1;
      end
      m_stop = nstop;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(cur_req, "rdata", bus_rdata, {m_addr, 2'b00, m_start, m_ask, 2'(m_chan)});
    chk(cur_req, "start_req", 32'(ch_start_req), m_start ? (32'd1 << m_chan) : 32'd0);
    chk(cur_req, "start_addr", ch_start_addr, {m_addr, 6'b0});
    chk(cur_req, "stop", 32'(ch_stop), 32'(m_stop));
    chk(cur_req, "wb_valid", 32'(wb_valid), 32'(m_ask));
    if (m_ask) begin
      chk(cur_req, "wb_addr", wb_addr, {m_addr, 6'b0} + 32'(4 * m_idx));
      chk(cur_req, "wb_data", wb_data, snapw(m_chan, m_idx));
      chk(cur_req, "snap_idx", 32'(snap_idx), 32'(m_idx));
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=<5000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(logic [31:0] d);
    bus_sel = 1'b1; bus_enable = 1'b1; bus_write = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    idle(3);
    chk("R1", "reset rdata", bus_rdata, 32'h0);
    chk("R1", "reset req", 32'(ch_start_req | ch_stop), 32'h0);
    chk("R1", "reset wb_valid", 32'(wb_valid), 32'h0);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R2";
    bus_wr(32'h1234_5641);
    chk("R2", "readback", bus_rdata, 32'h1234_5641);
    idle(1);

    cur_req = "R3";
    bus_wr(32'hABCD_0003);
    chk("R3", "bad chan ignored", bus_rdata, 32'h1234_5641);
    bus_wr(32'hABCD_0020);
    chk("R3", "reserved bit ignored", bus_rdata, 32'h1234_5641);

    cur_req = "R8";
    d = bus_rdata;
    d[1:0] = 2'd2;
    bus_wr(d | 32'h10);
    chk("R8", "stop pulse", 32'(ch_stop), 32'b100);
    idle(1);
    chk("R8", "stop gone", 32'(ch_stop), 32'b000);
    chk("R8", "stop not stored", bus_rdata, 32'h1234_5642);

    cur_req = "R4";
    bus_wr(32'h0000_8008);
    idle(2);
    chk("R4", "req held", 32'(ch_start_req), 32'b001);
    chk("R4", "start addr", ch_start_addr, 32'h0000_8000);

    cur_req = "R11";
    ch_start_ack = 3'b110;
    idle(2);
    ch_start_ack = 3'b000;
    chk("R11", "foreign ack", 32'(ch_start_req), 32'b001);

    cur_req = "R9";
    bus_wr(32'h5555_5546);
    chk("R9", "write while pending", bus_rdata, 32'h0000_8008);

    cur_req = "R4";
    ch_start_ack = 3'b001;
    @(negedge clk);
    ch_start_ack = 3'b000;
    chk("R4", "start cleared", bus_rdata, 32'h0000_8000);
    chk("R4", "req dropped", 32'(ch_start_req), 32'b000);

    cur_req = "R5";
    wb_ready = 1'b1;
    bus_wr(32'h0004_0085);
    chk("R5", "ask flag", bus_rdata, 32'h0004_0085);
    idle(10);

    cur_req = "R6";
    wb_ready = 1'b0;
    bus_wr(32'h0ABC_0046);
    for (int i = 0; i < 30; i++) begin
      wb_ready = (i % 3 == 1);
      if (i == 4) begin
        bus_sel = 1'b1; bus_enable = 1'b1; bus_write = 1'b1; bus_wdata = 32'h0000_0008;
      end else begin
        bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0;
      end
      @(negedge clk);
    end
    bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0;
    chk("R6", "dump done", bus_rdata, 32'h0ABC_0042);

    cur_req = "R7";
    wb_ready = 1'b1;
    bus_wr(32'h0000_3C84);
    idle(6);
    bus_wr(32'h0000_7C09);
    idle(2);
    chk("R7", "coincident write ignored", bus_rdata, 32'h0000_3C80);

    cur_req = "R10";
    bus_wr(32'h0000_111C);
    chk("R10", "stop wins", 32'(ch_stop), 32'b001);
    idle(1);
    chk("R10", "no launch", bus_rdata, 32'h0000_1100);
    bus_wr(32'h0000_220D);
    chk("R10", "ask wins", 32'(wb_valid), 32'h1);
    chk("R10", "no start", 32'(ch_start_req), 32'h0);
    idle(10);

    summary();
    $finish;
  end
endmodule